// File: doc/BRIEF.md
# Dual XOR-Feedback Shift Sequencer

This block produces two independent streams of pseudo-random gate patterns and step codes. Each channel holds a short shift register. It advances once for every rising edge seen on that channel's external step-clock pin. The bit that enters the first stage is the channel's external data level XORed with the bit leaving the last stage. When the clock and data sources are closely related, the patterns repeat in loops. Loosely related sources give sequences that look random.

Both external pins of each channel are asynchronous. Each passes through a multi-flop synchronizer into the system clock domain. The synchronized clock level is then turned into a single-cycle advance pulse on its rising transition. Every stage drives its own gate/indicator output. Each channel also presents a step code formed from the inverted stage bits, ready for an external converter. An all-clear register therefore gives the highest code.

Top module: `xfsr_dual`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, every stage of every channel is cleared. After that edge `stage_gate` reads all zeros and `step_code` reads all ones (15 per channel with 4 stages).
- R2: Each external pin passes through a 2-flop synchronizer. A step-clock rise that is present at system edge n becomes visible on the outputs after system edge n+2, and not earlier.
- R3: On each advance, stage k+1 takes the old value of stage k for every k from 1 to STAGES-1.
- R4: On each advance, stage 1 takes the synchronized data level XOR the old last-stage bit. It is 1 when exactly one of the two is 1 and 0 when both are 1.
- R5: `stage_gate` bit c*STAGES+k mirrors stage k+1 of channel c, so stage 1 sits at the low bit of its channel's slice.
- R6: `step_code` bits [c*STAGES +: STAGES] equal the bitwise inverse of channel c's stages, with stage 1 at code bit 0 (LSB) and the last stage at the MSB.
- R7: With no rising step-clock transition, the stages and both outputs hold their values whatever the data pin does, including across a falling clock transition.
- R8: The channels are independent. An advance on one channel leaves the other channel's outputs unchanged.
- R9: A step-clock level held high for any number of cycles produces exactly one advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_clk_in | input | LANES | Asynchronous step clock, one bit per channel |
| step_data_in | input | LANES | Asynchronous data level, one bit per channel |
| stage_gate | output | LANES*STAGES | Per-stage gate/indicator levels, registered |
| step_code | output | LANES*STAGES | Inverted stage bits per channel, registered |

## Verification
The bench builds the block with its default parameters: two channels, four stages and a two-flop synchronizer. With four stages the whole space of 16 states per channel can be reached, and a long random phase visits the XOR wrap from the last stage many times. Two channels are enough to check that one channel's advance leaves the other's slice untouched. The two-flop depth fixes the three-edge latency that the per-cycle reference model has to match exactly.

// File: rtl/xfsr_pkg.sv
// Package: shared defaults and the feedback rule of the dual shift sequencer.
// Assumes every consumer slices its own buses from these widths.
package xfsr_pkg;

    localparam int unsigned DEF_LANES      = 2;
    localparam int unsigned DEF_STAGES     = 4;
    localparam int unsigned DEF_SYNC_DEPTH = 2;

    // Phase of a step-clock pin as seen after synchronization.
    typedef enum logic [1:0] {
        PH_LOW  = 2'b00,
        PH_RISE = 2'b01,
        PH_HIGH = 2'b11,
        PH_FALL = 2'b10
    } step_phase_e;

    // Bit entering stage 1: external level XOR the bit leaving the last stage.
    function automatic logic feed_bit(input logic ext_level, input logic tail_bit);
        return ext_level ^ tail_bit;
    endfunction

endpackage

// File: rtl/xfsr_sync.sv
// Module: multi-flop synchronizer for one asynchronous level.
// Assumes DEPTH >= 2; the output is cleared by the synchronous reset.
module xfsr_sync #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    localparam int unsigned TOP = DEPTH - 1;

    logic [TOP:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[TOP-1:0], async_i};
        end
    end

    assign sync_o = chain_q[TOP];

endmodule

// File: rtl/xfsr_edge.sv
// Module: rising-transition detector that makes a one-cycle advance pulse.
// Assumes its input is already synchronous to clk.
module xfsr_edge
    import xfsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o
);

    logic        prev_q;
    step_phase_e phase;

    // Remember the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= level_i;
        end
    end

    // Classify the pair (previous, current) into a phase.
    always_comb begin
        phase = step_phase_e'({prev_q, level_i});
    end

    assign rise_o = (phase == PH_RISE);

    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o)
        else $error("advance pulse lasted more than one cycle");

endmodule

// File: rtl/xfsr_lane.sv
// Module: one channel's shift register with XOR feedback and registered outputs.
// Assumes adv_i is a single-cycle pulse and bit_i is synchronous to clk.
module xfsr_lane
    import xfsr_pkg::*;
#(
    parameter int unsigned STAGES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              bit_i,
    output logic [STAGES-1:0] gate_o,
    output logic [STAGES-1:0] code_o
);

    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] stage_q;
    logic [LAST:0] stage_d;
    logic [LAST:0] code_q;

    // Next register contents: shift up by one and feed the XOR bit at stage 1.
    always_comb begin
        stage_d = stage_q;
        if (adv_i) begin
            stage_d = {stage_q[LAST-1:0], feed_bit(bit_i, stage_q[LAST])};
        end
    end

    // Hold the stage bits; these also drive the gate outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    // Register the inverted code alongside the stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '1;
        end else begin
            code_q <= ~stage_d;
        end
    end

    assign gate_o = stage_q;
    assign code_o = code_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (stage_q == '0 && code_q == '1))
        else $error("stages not cleared after reset");

    // R3
    shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |=> stage_q[LAST:1] == $past(stage_q[LAST-1:0]))
        else $error("stage shift wrong");

    // R4
    feed_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |=> stage_q[0] == ($past(bit_i) ^ $past(stage_q[LAST])))
        else $error("stage 1 feed is not data XOR tail");

    // R6
    code_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_q == ~stage_q)
        else $error("code is not the inverse of the stages");

    // R7
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(stage_q) && $stable(code_q))
        else $error("lane changed without an advance");

endmodule

// File: rtl/xfsr_dual.sv
// Module: top of the dual XOR-feedback shift sequencer.
// Each channel synchronizes its own step clock and data pin, detects clock
// rises and advances its own shift register. Assumes LANES >= 1, STAGES >= 2.
module xfsr_dual
    import xfsr_pkg::*;
#(
    parameter int unsigned LANES      = DEF_LANES,
    parameter int unsigned STAGES     = DEF_STAGES,
    parameter int unsigned SYNC_DEPTH = DEF_SYNC_DEPTH
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LANES-1:0]          step_clk_in,
    input  logic [LANES-1:0]          step_data_in,
    output logic [LANES*STAGES-1:0]   stage_gate,
    output logic [LANES*STAGES-1:0]   step_code
);

    localparam int unsigned BUS_W = LANES * STAGES;

    logic [LANES-1:0] clk_s;
    logic [LANES-1:0] data_s;
    logic [LANES-1:0] adv;
    logic [BUS_W-1:0] gate_bus;
    logic [BUS_W-1:0] code_bus;

    // Build one complete channel per lane.
    for (genvar c = 0; c < LANES; c++) begin : g_lane
        xfsr_sync #(.DEPTH(SYNC_DEPTH)) u_clk_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (step_clk_in[c]),
            .sync_o  (clk_s[c])
        );

        xfsr_sync #(.DEPTH(SYNC_DEPTH)) u_data_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (step_data_in[c]),
            .sync_o  (data_s[c])
        );

        xfsr_edge u_rise (
            .clk     (clk),
            .rst_n   (rst_n),
            .level_i (clk_s[c]),
            .rise_o  (adv[c])
        );

        xfsr_lane #(.STAGES(STAGES)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .adv_i  (adv[c]),
            .bit_i  (data_s[c]),
            .gate_o (gate_bus[c*STAGES +: STAGES]),
            .code_o (code_bus[c*STAGES +: STAGES])
        );

        // R8
        lane_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !adv[c] |=> $stable(gate_bus[c*STAGES +: STAGES]))
            else $error("lane moved on another lane's advance");
    end

    assign stage_gate = gate_bus;
    assign step_code  = code_bus;

endmodule

// File: tb/xfsr_dual_bench.sv
module xfsr_dual_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 2;
    localparam int STAGES     = 4;
    localparam int MASK       = (1 << STAGES) - 1;
    localparam int WATCHDOG   = 150000;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [LANES-1:0]        step_clk_in = '0;
    logic [LANES-1:0]        step_data_in = '0;
    logic [LANES*STAGES-1:0] stage_gate;
    logic [LANES*STAGES-1:0] step_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit cmp_en = 0;

    // Behavioural reference: input history seen at each system edge.
    int h1c[LANES], h2c[LANES], h3c[LANES];
    int h1d[LANES], h2d[LANES];
    int model[LANES];

    xfsr_dual #(.LANES(LANES), .STAGES(STAGES), .SYNC_DEPTH(2)) u_xfsr_dual (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_clk_in  (step_clk_in),
        .step_data_in (step_data_in),
        .stage_gate   (stage_gate),
        .step_code    (step_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int gate_of(input int ch);
        return int'((stage_gate >> (ch*STAGES)) & MASK);
    endfunction

    function automatic int code_of(input int ch);
        return int'((step_code >> (ch*STAGES)) & MASK);
    endfunction

    // Reference model: a rise seen two edges ago advances the register.
    always @(posedge clk) begin
        for (int c = 0; c < LANES; c++) begin
            if (!rst_n) begin
                h1c[c] = 0; h2c[c] = 0; h3c[c] = 0;
                h1d[c] = 0; h2d[c] = 0;
                model[c] = 0;
            end else begin
                if (h2c[c] == 1 && h3c[c] == 0)
                    model[c] = ((model[c] << 1) | (h2d[c] ^ ((model[c] >> (STAGES-1)) & 1))) & MASK;
                h3c[c] = h2c[c];
                h2c[c] = h1c[c];
                h1c[c] = int'(step_clk_in[c]);
                h2d[c] = h1d[c];
                h1d[c] = int'(step_data_in[c]);
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            for (int c = 0; c < LANES; c++) begin
                chk($sformatf("R5 gate lane%0d", c), gate_of(c), model[c]);
                chk($sformatf("R6 code lane%0d", c), code_of(c), (~model[c]) & MASK);
            end
        end
    end

    task automatic pulse(input int ch, input bit d);
        @(negedge clk);
        step_data_in[ch] = d;
        step_clk_in[ch]  = 1'b1;
        repeat (3) @(negedge clk);
        step_clk_in[ch]  = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_en = 1;
        // R1: reset state
        chk("R1 gate after reset", int'(stage_gate), 0);
        chk("R1 code after reset", int'(step_code), 8'hFF);

        // R3, R4: fill lane 0 with ones
        for (int i = 0; i < 4; i++) pulse(0, 1'b1);
        chk("R3 lane0 filled", gate_of(0), 4'hF);
        chk("R6 lane0 code all ones stages", code_of(0), 0);
        pulse(0, 1'b1);
        chk("R4 both high feeds 0", gate_of(0), 4'hE);
        pulse(0, 1'b0);
        chk("R4 tail only feeds 1", gate_of(0), 4'hD);

        // R7: data activity with no clock rise
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            step_data_in[0] = ~step_data_in[0];
        end
        repeat (4) @(negedge clk);
        chk("R7 hold under data toggles", gate_of(0), 4'hD);

        // R9: long high level gives one advance
        @(negedge clk);
        step_data_in[0] = 1'b0;
        step_clk_in[0]  = 1'b1;
        repeat (25) @(negedge clk);
        chk("R9 single advance on held level", gate_of(0), 4'hB);
        step_clk_in[0] = 1'b0;
        repeat (6) @(negedge clk);
        chk("R7 falling edge holds", gate_of(0), 4'hB);

        // R8: lane 1 advances, lane 0 unchanged
        pulse(1, 1'b1);
        chk("R8 lane1 advanced", gate_of(1), 4'h1);
        chk("R8 lane0 untouched", gate_of(0), 4'hB);

        // R2: latency of two synchronizer flops plus the register
        @(negedge clk);
        step_data_in[1] = 1'b0;
        step_clk_in[1]  = 1'b1;
        @(negedge clk);
        chk("R2 no change after one edge", gate_of(1), 4'h1);
        @(negedge clk);
        chk("R2 no change after two edges", gate_of(1), 4'h1);
        @(negedge clk);
        chk("R2 change after three edges", gate_of(1), 4'h2);
        step_clk_in[1] = 1'b0;
        repeat (4) @(negedge clk);

        // Random phase on both lanes, checked every cycle by the model
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            for (int c = 0; c < LANES; c++) begin
                if ($urandom_range(0, 3) == 0) step_clk_in[c] = ~step_clk_in[c];
                step_data_in[c] = 1'($urandom_range(0, 1));
            end
        end

        // R1: reset in mid-run
        @(negedge clk);
        step_clk_in  = '0;
        step_data_in = '0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 gate after mid-run reset", int'(stage_gate), 0);
        chk("R1 code after mid-run reset", int'(step_code), 8'hFF);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule